// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Wake-Event Line Controller

This block watches a bank of asynchronous input lines (18 by default). On each line it finds rising edges, falling edges or both, as software selects. It turns every selected edge into an interrupt request that stays up until software clears it, into a single-cycle wake-up event pulse, or into both. The interrupt path stores each line's request in a pending bit that software clears by writing a one to it. The event path stores nothing: it produces one pulse on a shared output and never sets a pending bit.

Software programs the block through a flat register port with six registers: a rising-select mask, a falling-select mask, an interrupt enable mask, an event enable mask, a software trigger and the pending bits. Writing a one to a bit of the software trigger register acts like a hardware edge on that line, and the trigger selects do not apply to it. The trigger bit clears itself one cycle later. Each input passes through a two-flop synchronizer. A third flop holds the line's previous level, so edges are found only after the line's value has settled.

Top module: `edge_line_ctrl`

## Requirements
- R1: Registers are reached by `reg_addr`: 0 = rising select, 1 = falling select, 2 = interrupt mask, 3 = event mask, 4 = software trigger, 5 = pending. Bit i of every register belongs to line i. `reg_rdata` shows the addressed register combinationally. Addresses 6 and 7 read as zero, and writes to them change nothing.
- R2: After reset every register is zero, `irq_req` is all zero and `wake_evt` is low.
- R3: A 0-to-1 change on a line whose rising-select bit and interrupt-mask bit are both 1 sets that line's pending bit on the third rising clock edge after the input change. `irq_req[i]` always equals pending bit i AND interrupt-mask bit i.
- R4: A 1-to-0 change is detected when the falling-select bit is 1. With both select bits set, either direction is detected.
- R5: A selected edge on a line whose interrupt-mask bit is 0 leaves that line's pending bit at 0.
- R6: A selected edge on a line whose event-mask bit is 1 raises `wake_evt` for exactly one cycle, with the same latency as R3, and does not set the pending bit.
- R7: Writing 1 to a pending bit clears it on the next clock edge. Writing 0 leaves it unchanged. A pending bit falls only through such a clear.
- R8: Writing 1 to a bit of the software trigger register causes, on the next clock edge, the interrupt and/or event that the line's masks allow, whatever the select bits are. The trigger bit then reads back as 0.
- R9: When a trigger on a line and a clear of the same line's pending bit fall in the same cycle, the pending bit ends at 1.
- R10: A change on a line whose edge direction is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous input lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | NUM_LINES | Write data, one bit per line |
| reg_rdata | output | NUM_LINES | Read data of the addressed register |
| irq_req | output | NUM_LINES | Per-line interrupt request |
| wake_evt | output | 1 | One-cycle wake-up event pulse |

## Verification
A pending bit that is set or lost wrongly shows on `irq_req` on the clock edge right after the fault, provided the line is unmasked. Because readback is combinational, it also shows on `reg_rdata` at address 5 in the same cycle. A fault in the synchronizer or the edge finder moves the set point away from the third edge after the input change, and the per-cycle model catches it in that cycle. If the event path wrongly touched the pending state, a masked interrupt would appear in the pending readback even though `irq_req` stays low, so the bench reads pending back after every event-only stimulus.

// File: rtl/elc_pkg.sv
package elc_pkg;

  localparam int unsigned ELC_ADDR_W = 3;

  localparam logic [ELC_ADDR_W-1:0] ADDR_RISE   = 3'd0;
  localparam logic [ELC_ADDR_W-1:0] ADDR_FALL   = 3'd1;
  localparam logic [ELC_ADDR_W-1:0] ADDR_IMASK  = 3'd2;
  localparam logic [ELC_ADDR_W-1:0] ADDR_EMASK  = 3'd3;
  localparam logic [ELC_ADDR_W-1:0] ADDR_SWTRIG = 3'd4;
  localparam logic [ELC_ADDR_W-1:0] ADDR_PEND   = 3'd5;

  // One line: did the settled level move in a selected direction?
  function automatic logic edge_hit_f(input logic now_lvl, input logic old_lvl,
                                      input logic rise_en, input logic fall_en);
    logic went_up;
    logic went_down;
    went_up   = now_lvl & ~old_lvl;
    went_down = ~now_lvl & old_lvl;
    return (rise_en & went_up) | (fall_en & went_down);
  endfunction

  // One pending bit: a set beats a clear in the same cycle.
  function automatic logic pend_next_f(input logic cur, input logic set_i,
                                       input logic clr_i);
    return set_i | (cur & ~clr_i);
  endfunction

endpackage

// File: rtl/elc_sync_stage.sv
module elc_sync_stage #(
  parameter int unsigned NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] lines_async,
  output logic [NUM_LINES-1:0] level_now,
  output logic [NUM_LINES-1:0] level_prev
);

  logic [NUM_LINES-1:0] meta_q;
  logic [NUM_LINES-1:0] stab_q;
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= lines_async;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level_now  = stab_q;
  assign level_prev = prev_q;

endmodule

// File: rtl/elc_edge_unit.sv
module elc_edge_unit #(
  parameter int unsigned NUM_LINES = 18
) (
  input  logic [NUM_LINES-1:0] level_now,
  input  logic [NUM_LINES-1:0] level_prev,
  input  logic [NUM_LINES-1:0] rise_sel,
  input  logic [NUM_LINES-1:0] fall_sel,
  output logic [NUM_LINES-1:0] hw_hit
);

  for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
    assign hw_hit[li] = elc_pkg::edge_hit_f(level_now[li], level_prev[li],
                                            rise_sel[li], fall_sel[li]);
  end

endmodule

// File: rtl/elc_cfg_regs.sv
module elc_cfg_regs #(
  parameter int unsigned NUM_LINES = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [elc_pkg::ELC_ADDR_W-1:0] reg_addr,
  input  logic [NUM_LINES-1:0]          reg_wdata,
  input  logic [NUM_LINES-1:0]          pend_q,
  output logic [NUM_LINES-1:0]          rise_sel,
  output logic [NUM_LINES-1:0]          fall_sel,
  output logic [NUM_LINES-1:0]          imask,
  output logic [NUM_LINES-1:0]          emask,
  output logic [NUM_LINES-1:0]          sw_pulse,
  output logic [NUM_LINES-1:0]          pend_clr,
  output logic [NUM_LINES-1:0]          reg_rdata
);

  import elc_pkg::*;

  logic wr_rise, wr_fall, wr_imask, wr_emask, wr_sw, wr_pend;

  assign wr_rise  = reg_we && (reg_addr == ADDR_RISE);
  assign wr_fall  = reg_we && (reg_addr == ADDR_FALL);
  assign wr_imask = reg_we && (reg_addr == ADDR_IMASK);
  assign wr_emask = reg_we && (reg_addr == ADDR_EMASK);
  assign wr_sw    = reg_we && (reg_addr == ADDR_SWTRIG);
  assign wr_pend  = reg_we && (reg_addr == ADDR_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_sel <= '0;
      fall_sel <= '0;
      imask    <= '0;
      emask    <= '0;
      sw_pulse <= '0;
    end else begin
      if (wr_rise)  rise_sel <= reg_wdata;
      if (wr_fall)  fall_sel <= reg_wdata;
      if (wr_imask) imask    <= reg_wdata;
      if (wr_emask) emask    <= reg_wdata;
      // self-clearing: lives exactly one cycle unless rewritten
      sw_pulse <= wr_sw ? reg_wdata : '0;
    end
  end

  assign pend_clr = wr_pend ? reg_wdata : '0;

  always_comb begin
    case (reg_addr)
      ADDR_RISE:   reg_rdata = rise_sel;
      ADDR_FALL:   reg_rdata = fall_sel;
      ADDR_IMASK:  reg_rdata = imask;
      ADDR_EMASK:  reg_rdata = emask;
      ADDR_SWTRIG: reg_rdata = sw_pulse;
      ADDR_PEND:   reg_rdata = pend_q;
      default:     reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/elc_pend_evt.sv
module elc_pend_evt #(
  parameter int unsigned NUM_LINES = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] trig_vec,
  input  logic [NUM_LINES-1:0] imask,
  input  logic [NUM_LINES-1:0] emask,
  input  logic [NUM_LINES-1:0] pend_clr,
  output logic [NUM_LINES-1:0] irq_set,
  output logic [NUM_LINES-1:0] evt_hit,
  output logic [NUM_LINES-1:0] pend_q,
  output logic [NUM_LINES-1:0] irq_req,
  output logic                 wake_evt
);

  logic wake_q;

  assign irq_set = trig_vec & imask;
  assign evt_hit = trig_vec & emask;

  for (genvar li = 0; li < NUM_LINES; li++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[li] <= 1'b0;
      else        pend_q[li] <= elc_pkg::pend_next_f(pend_q[li], irq_set[li],
                                                     pend_clr[li]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |evt_hit;
  end

  assign irq_req  = pend_q & imask;
  assign wake_evt = wake_q;

endmodule

// File: rtl/edge_line_ctrl.sv
module edge_line_ctrl #(
  parameter int unsigned NUM_LINES = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LINES-1:0]          line_in,
  input  logic                          reg_we,
  input  logic [elc_pkg::ELC_ADDR_W-1:0] reg_addr,
  input  logic [NUM_LINES-1:0]          reg_wdata,
  output logic [NUM_LINES-1:0]          reg_rdata,
  output logic [NUM_LINES-1:0]          irq_req,
  output logic                          wake_evt
);

  logic [NUM_LINES-1:0] level_now, level_prev;
  logic [NUM_LINES-1:0] rise_sel, fall_sel, imask, emask;
  logic [NUM_LINES-1:0] sw_pulse, pend_clr, pend_q;
  logic [NUM_LINES-1:0] hw_hit, trig_vec, irq_set, evt_hit;

  elc_sync_stage #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .lines_async(line_in),
    .level_now(level_now), .level_prev(level_prev)
  );

  elc_edge_unit #(.NUM_LINES(NUM_LINES)) u_edge (
    .level_now(level_now), .level_prev(level_prev),
    .rise_sel(rise_sel), .fall_sel(fall_sel), .hw_hit(hw_hit)
  );

  elc_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend_q(pend_q),
    .rise_sel(rise_sel), .fall_sel(fall_sel), .imask(imask), .emask(emask),
    .sw_pulse(sw_pulse), .pend_clr(pend_clr), .reg_rdata(reg_rdata)
  );

  // software trigger joins the hardware edges ahead of both masks
  assign trig_vec = hw_hit | sw_pulse;

  elc_pend_evt #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .trig_vec(trig_vec), .imask(imask),
    .emask(emask), .pend_clr(pend_clr), .irq_set(irq_set),
    .evt_hit(evt_hit), .pend_q(pend_q), .irq_req(irq_req),
    .wake_evt(wake_evt)
  );

endmodule

// File: rtl/elc_checker.sv
module elc_checker #(
  parameter int unsigned NUM_LINES = 18
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          reg_we,
  input logic [elc_pkg::ELC_ADDR_W-1:0] reg_addr,
  input logic [NUM_LINES-1:0]          trig_vec,
  input logic [NUM_LINES-1:0]          imask,
  input logic [NUM_LINES-1:0]          emask,
  input logic [NUM_LINES-1:0]          irq_set,
  input logic [NUM_LINES-1:0]          pend_clr,
  input logic [NUM_LINES-1:0]          pend_q,
  input logic [NUM_LINES-1:0]          sw_pulse,
  input logic                          wake_evt
);

  // R5
  pend_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(imask)) == '0));

  // R7
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & $past(pend_clr) & ~$past(irq_set) & pend_q) == '0));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q) & ~pend_q & ~$past(pend_clr)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(irq_set) & ~pend_q) == '0));

  // R6
  evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |-> $past(|(trig_vec & emask)));

  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sw_pulse) && !(reg_we && reg_addr == elc_pkg::ADDR_SWTRIG))
      |=> (sw_pulse == '0));

endmodule

bind edge_line_ctrl elc_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .trig_vec(trig_vec), .imask(imask), .emask(emask), .irq_set(irq_set),
  .pend_clr(pend_clr), .pend_q(pend_q), .sw_pulse(sw_pulse),
  .wake_evt(wake_evt)
);

// File: tb/edge_line_ctrl_test.sv
`timescale 1ns/100ps
module edge_line_ctrl_test;

  localparam int NL = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] line_in = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [NL-1:0] reg_wdata = '0;
  logic [NL-1:0] reg_rdata;
  logic [NL-1:0] irq_req;
  logic          wake_evt;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  edge_line_ctrl #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .wake_evt(wake_evt)
  );

  // ---------------- reference model ----------------
  int hist[$];               // input history, newest at the back
  bit m_rs[NL], m_fs[NL], m_im[NL], m_em[NL], m_sw[NL], m_pd[NL];
  bit m_evt;

  function automatic int line_at(int age, int li);
    // age 0 = newest sample
    if (hist.size() <= age) return 0;
    return (hist[hist.size()-1-age] >> li) & 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < NL; i++) begin
        m_rs[i] = 0; m_fs[i] = 0; m_im[i] = 0; m_em[i] = 0;
        m_sw[i] = 0; m_pd[i] = 0;
      end
      m_evt = 0;
    end else begin
      bit any_evt;
      any_evt = 0;
      for (int i = 0; i < NL; i++) begin
        // settled level is two samples old, previous level three
        int a, b;
        bit fire, clr;
        a = line_at(1, i);
        b = line_at(2, i);
        fire = m_sw[i] || (m_rs[i] && a == 1 && b == 0) ||
               (m_fs[i] && a == 0 && b == 1);
        clr = reg_we && reg_addr == 3'd5 && reg_wdata[i];
        if (fire && m_im[i]) m_pd[i] = 1;
        else if (clr)        m_pd[i] = 0;
        if (fire && m_em[i]) any_evt = 1;
        m_sw[i] = 0;
        if (reg_we) begin
          case (reg_addr)
            3'd0: m_rs[i] = reg_wdata[i];
            3'd1: m_fs[i] = reg_wdata[i];
            3'd2: m_im[i] = reg_wdata[i];
            3'd3: m_em[i] = reg_wdata[i];
            3'd4: m_sw[i] = reg_wdata[i];
            default: ;
          endcase
        end
      end
      m_evt = any_evt;
      hist.push_back(int'(line_in));
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  function automatic logic [NL-1:0] model_read(logic [2:0] a);
    logic [NL-1:0] v;
    v = '0;
    for (int i = 0; i < NL; i++) begin
      case (a)
        3'd0: v[i] = m_rs[i];
        3'd1: v[i] = m_fs[i];
        3'd2: v[i] = m_im[i];
        3'd3: v[i] = m_em[i];
        3'd4: v[i] = m_sw[i];
        3'd5: v[i] = m_pd[i];
        default: v[i] = 1'b0;
      endcase
    end
    return v;
  endfunction

  function automatic logic [NL-1:0] model_irq();
    logic [NL-1:0] v;
    for (int i = 0; i < NL; i++) v[i] = m_pd[i] & m_im[i];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 irq_req vs model", 32'(irq_req), 32'(model_irq()));
      chk("R6 wake_evt vs model", 32'(wake_evt), 32'(m_evt));
      chk("R1 reg_rdata vs model", 32'(reg_rdata), 32'(model_read(reg_addr)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [NL-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [NL-1:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(4);
    // R2: reset state
    for (int a = 0; a < 8; a++) rd_chk("R2 reset register", 3'(a), '0);
    chk("R2 reset irq", 32'(irq_req), 0);
    chk("R2 reset event", 32'(wake_evt), 0);
    rst_n = 1'b1;
    step(2);

    // R1: configuration and readback
    wr(3'd0, 18'h00011);       // rising on lines 0 and 4
    wr(3'd1, 18'h00002);       // falling on line 1
    wr(3'd2, 18'h20103);       // irq mask lines 0,1,8,17
    rd_chk("R1 rise readback", 3'd0, 18'h00011);
    rd_chk("R1 imask readback", 3'd2, 18'h20103);
    wr(3'd7, 18'h3FFFF);
    rd_chk("R1 unused address", 3'd7, '0);
    rd_chk("R1 write to unused address ignored", 3'd2, 18'h20103);

    // R3: rising edge on line 0, latency of three edges
    line_in[0] = 1'b1;
    step(2);
    chk("R3 no irq before third edge", 32'(irq_req[0]), 0);
    step(1);
    chk("R3 irq on third edge", 32'(irq_req[0]), 1);

    // R10: rising change on line 1 (only falling selected)
    line_in[1] = 1'b1;
    step(4);
    chk("R10 unselected direction", 32'(irq_req[1]), 0);
    // R4: falling on line 1
    line_in[1] = 1'b0;
    step(3);
    chk("R4 falling edge", 32'(irq_req[1]), 1);

    // R7: clear line 0, write zero does nothing
    wr(3'd5, 18'h00001);
    chk("R7 clear", 32'(irq_req[0]), 0);
    wr(3'd5, 18'h00000);
    chk("R7 write zero keeps line1", 32'(irq_req[1]), 1);
    // R3: mask removal hides request, pending stays
    wr(3'd2, 18'h20101);
    chk("R3 masked request low", 32'(irq_req[1]), 0);
    rd_chk("R3 pending kept", 3'd5, 18'h00002);
    wr(3'd5, 18'h00002);

    // R4: both edges on line 17
    wr(3'd0, 18'h20011);
    wr(3'd1, 18'h20002);
    line_in[17] = 1'b1;
    step(3);
    chk("R4 both-rise", 32'(irq_req[17]), 1);
    wr(3'd5, 18'h20000);
    line_in[17] = 1'b0;
    step(3);
    chk("R4 both-fall", 32'(irq_req[17]), 1);
    wr(3'd5, 18'h20000);

    // R5: line 4 rising, irq mask 0
    line_in[4] = 1'b1;
    step(4);
    rd_chk("R5 masked line no pending", 3'd5, 18'h00000);
    line_in[4] = 1'b0;
    step(4);

    // R6: event on line 4
    wr(3'd3, 18'h00110);
    line_in[4] = 1'b1;
    step(2);
    chk("R6 event not early", 32'(wake_evt), 0);
    step(1);
    chk("R6 event pulse", 32'(wake_evt), 1);
    step(1);
    chk("R6 event one cycle", 32'(wake_evt), 0);
    rd_chk("R6 event leaves pending", 3'd5, 18'h00000);

    // R8: software trigger on line 8 (no select bits)
    wr(3'd4, 18'h00100);
    rd_chk("R8 trigger visible", 3'd4, 18'h00100);
    step(1);
    chk("R8 sw irq", 32'(irq_req[8]), 1);
    chk("R8 sw event", 32'(wake_evt), 1);
    rd_chk("R8 self clear", 3'd4, 18'h00000);
    step(1);
    chk("R8 sw event one cycle", 32'(wake_evt), 0);

    // R9: trigger and clear of line 8 collide
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 18'h00100;
    step(1);
    reg_addr = 3'd5;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
    chk("R9 set wins", 32'(irq_req[8]), 1);
    wr(3'd5, 18'h00100);
    chk("R9 later clear", 32'(irq_req[8]), 0);

    step(5);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule